// File: doc/BRIEF.md
# Three-wire serial EEPROM device controller

This block is the device-side logic of a small serial EEPROM with 64 words of 16 bits. The host drives three pins: chip select, serial clock and serial data-in. The block samples them with its own system clock, collects a start bit, a two-bit opcode and a six-bit address, and then carries out one of seven instructions. A read sends a word back on data-out. A word write, a word erase, a whole-array write and a whole-array erase each start a self-timed programming cycle. Two further instructions lock and unlock programming.

A register array stands in for the nonvolatile cells. A counter, with its length set by a parameter in system clocks, models the self-timed cycle. The array content changes at the end of that cycle. While a cycle runs, the host can drop chip select and raise it again. Data-out then becomes a live status bit: 0 while the cycle is busy and 1 once it has finished. Data-out is modelled as a value plus a separate output enable, and the enable is low whenever the pin would float.

Top module: `tw_eeprom_dev`

## Requirements
- R1: After reset, programming is locked, `dout_oe` is 0, no cycle is running and every array word reads as 16'hFFFF.
- R2: An instruction starts at a rising edge of `cs`. Data is sampled on rising `sk` edges while `cs` is high. Zeros before the start bit (a 1) are ignored, and `sk` edges while `cs` is low have no effect. After the start bit come the opcode (2 bits) and then the address (6 bits), both MSB first. Opcodes: 10 read, 01 write, 11 erase, 00 special group.
- R3: After the last address bit of a read, data-out drives a 0 dummy bit. Each following rising `sk` edge presents the next data bit, MSB first, 16 in all. The rising edge after the 16th bit releases `dout_oe`. Reads work whether programming is locked or not.
- R4: In the special group, the two top address bits select the function: 11 unlocks programming, 00 locks it, 10 erases the whole array and 01 writes the whole array. Unlocked stays unlocked until a lock instruction or a reset.
- R5: While programming is locked, write, erase, whole-array erase and whole-array write leave the array unchanged and start no cycle.
- R6: A write takes 16 data bits, MSB first, after the address. Its cycle starts after the last data bit, and the addressed word then holds the data.
- R7: An erase sets the addressed word to 16'hFFFF and leaves every other word unchanged.
- R8: A whole-array erase sets every word to 16'hFFFF. A whole-array write takes 16 data bits and stores them in every word.
- R9: The self-timed cycle lasts PROG_CYCLES system clocks. Rising `sk` edges during the cycle are ignored.
- R10: If `cs` goes low and then rises again while a cycle started by this instruction is running, `dout_oe` goes to 1. `dout` shows 0 while busy and 1 once the cycle has ended, and holds that 1 until `cs` falls.
- R11: If `cs` rises only after the cycle has ended, no status is shown and `dout_oe` stays 0.
- R12: `dout_oe` is 0 whenever `cs` is low, and also when the block is not in a read or showing status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the host |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the device |
| dout | output | 1 | Serial data or ready/busy status out |
| dout_oe | output | 1 | High when `dout` is driven; low models high impedance |

## Verification
The hardest state to reach from the ports is a programming cycle that is still running while the host has already used up its one status request. In that state the serial clock must be proven dead, not merely ignored by an idle decoder. The bench makes the programming cycle long and starts a write. It then raises chip select once to read the busy status, and raises it a second time. On that second window it clocks a complete read instruction well inside the busy window, and checks that data-out never becomes enabled. Cycle length is measured by polling the status bit clock by clock, and every word is written and read back through a full address sweep.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SP_LOCK    = 2'b00,
    SP_FILLALL = 2'b01,
    SP_WIPEALL = 2'b10,
    SP_UNLOCK  = 2'b11
  } sp_e;

  typedef enum logic [1:0] {
    PK_WORD_WR = 2'b00,
    PK_WORD_ER = 2'b01,
    PK_ALL_WR  = 2'b10,
    PK_ALL_ER  = 2'b11
  } prog_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_OPC, FS_ADR, FS_DAT, FS_RD, FS_DONE
  } fstate_e;

  // whole-array kinds touch every word
  function automatic logic hits_all(input prog_e k);
    return (k == PK_ALL_WR) || (k == PK_ALL_ER);
  endfunction

  // erase kinds store all ones instead of the shifted data
  function automatic logic fills_ones(input prog_e k);
    return (k == PK_WORD_ER) || (k == PK_ALL_ER);
  endfunction

  function automatic sp_e special_sel(input logic [1:0] top2);
    return sp_e'(top2);
  endfunction

endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], din[i]};
    end
    assign lvl[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (start && cnt == '0)   cnt <= CW'(CYCLES);
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/tw_word_array.sv
module tw_word_array
  import tw_eeprom_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  prog_e             kind,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] new_word;

  assign new_word = fills_ones(kind) ? '1 : wdata;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = commit && (hits_all(kind) || waddr == ADDR_W'(w));
    always_ff @(posedge clk) begin
      if (rst)      mem[w] <= '1;
      else if (hit) mem[w] <= new_word;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tw_cmd_front.sv
module tw_cmd_front
  import tw_eeprom_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              sk_rise,
  input  logic              di_lvl,
  input  logic              busy,
  input  logic              wen,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output prog_e             kind_o,
  output logic              ev_prog,
  output logic              ev_unlock,
  output logic              ev_lock,
  output logic              rd_active,
  output logic              rd_bit
);
  localparam int MAXN = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW   = $clog2(MAXN + 1);

  fstate_e           state;
  logic [1:0]        op_q;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  prog_e             kind_q;
  logic [ADDR_W-1:0] addr_shift;
  logic              sk_take;

  assign addr_shift = {addr_q[ADDR_W-2:0], di_lvl};
  assign sk_take    = sk_rise && cs_lvl && !cs_rise && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FS_IDLE;
      op_q      <= '0;
      cnt       <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      kind_q    <= PK_WORD_WR;
      rd_bit    <= 1'b0;
      ev_prog   <= 1'b0;
      ev_unlock <= 1'b0;
      ev_lock   <= 1'b0;
    end else begin
      ev_prog   <= 1'b0;
      ev_unlock <= 1'b0;
      ev_lock   <= 1'b0;
      if (!cs_lvl || cs_rise) begin
        state <= FS_IDLE;
      end else if (sk_take) begin
        case (state)
          FS_IDLE: if (di_lvl) begin
            state <= FS_OPC;
            cnt   <= '0;
          end
          FS_OPC: begin
            op_q <= {op_q[0], di_lvl};
            if (cnt == CW'(1)) begin
              state <= FS_ADR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          FS_ADR: begin
            addr_q <= addr_shift;
            if (cnt == CW'(ADDR_W - 1)) begin
              cnt   <= '0;
              state <= FS_DONE;
              case (op_q)
                OP_READ: begin
                  state  <= FS_RD;
                  cnt    <= CW'(DATA_W);
                  rd_bit <= 1'b0;
                end
                OP_WRITE: begin
                  kind_q <= PK_WORD_WR;
                  if (wen) state <= FS_DAT;
                end
                OP_ERASE: begin
                  kind_q  <= PK_WORD_ER;
                  ev_prog <= wen;
                end
                default: begin
                  case (special_sel(addr_shift[ADDR_W-1 -: 2]))
                    SP_UNLOCK: ev_unlock <= 1'b1;
                    SP_LOCK:   ev_lock   <= 1'b1;
                    SP_WIPEALL: begin
                      kind_q  <= PK_ALL_ER;
                      ev_prog <= wen;
                    end
                    default: begin
                      kind_q <= PK_ALL_WR;
                      if (wen) state <= FS_DAT;
                    end
                  endcase
                end
              endcase
            end else cnt <= cnt + 1'b1;
          end
          FS_DAT: begin
            data_q <= {data_q[DATA_W-2:0], di_lvl};
            if (cnt == CW'(DATA_W - 1)) begin
              ev_prog <= 1'b1;
              state   <= FS_DONE;
            end else cnt <= cnt + 1'b1;
          end
          FS_RD: begin
            if (cnt == '0) state <= FS_DONE;
            else begin
              rd_bit <= rd_word[cnt - CW'(1)];
              cnt    <= cnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active = (state == FS_RD);
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign kind_o    = kind_q;
endmodule

// File: rtl/tw_eeprom_dev.sv
module tw_eeprom_dev
  import tw_eeprom_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  logic [2:0]        lvl;
  logic              cs_lvl, sk_lvl, di_lvl;
  logic              cs_d, sk_d, cs_rise, sk_rise;
  logic              busy, done;
  logic              ev_prog, ev_unlock, ev_lock;
  logic              rd_active, rd_bit;
  logic              wen_q, armed, status_on;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data, rd_word;
  prog_e             kind;

  tw_pin_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({cs, sk, di}), .lvl(lvl)
  );
  assign cs_lvl = lvl[2];
  assign sk_lvl = lvl[1];
  assign di_lvl = lvl[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_d <= cs_lvl;
      sk_d <= sk_lvl;
    end
  end
  assign cs_rise = cs_lvl && !cs_d;
  assign sk_rise = sk_lvl && !sk_d;

  tw_cmd_front #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .sk_rise(sk_rise), .di_lvl(di_lvl), .busy(busy), .wen(wen_q),
    .rd_word(rd_word), .addr_o(addr), .data_o(data), .kind_o(kind),
    .ev_prog(ev_prog), .ev_unlock(ev_unlock), .ev_lock(ev_lock),
    .rd_active(rd_active), .rd_bit(rd_bit)
  );

  tw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(ev_prog), .busy(busy), .done(done)
  );

  tw_word_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst(rst), .commit(done), .kind(kind), .waddr(addr),
    .wdata(data), .raddr(addr), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q     <= 1'b0;
      armed     <= 1'b0;
      status_on <= 1'b0;
    end else begin
      if (ev_unlock)    wen_q <= 1'b1;
      else if (ev_lock) wen_q <= 1'b0;

      if (ev_prog)      armed <= 1'b1;
      else if (cs_rise) armed <= 1'b0;

      if (!cs_lvl)                        status_on <= 1'b0;
      else if (cs_rise && armed && busy)  status_on <= 1'b1;
    end
  end

  assign dout_oe = rd_active || status_on;
  assign dout    = status_on ? !busy : (rd_active && rd_bit);
endmodule

// File: rtl/tw_eeprom_dev_chk.sv
module tw_eeprom_dev_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst,
  input logic cs_lvl,
  input logic busy,
  input logic wen,
  input logic status_on,
  input logic dout,
  input logic dout_oe
);
  localparam int CW = $clog2(PROG_CYCLES + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  p_reset_locked_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!wen && !busy && !dout_oe));

  p_prog_needs_wen_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen);

  p_cycle_len_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == CW'(PROG_CYCLES)));

  p_busy_shows_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (status_on && busy) |-> (dout_oe && !dout));

  p_status_needs_busy_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(status_on) |-> $past(busy));

  p_oe_needs_cs_r12: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl |=> !dout_oe);
endmodule

bind tw_eeprom_dev tw_eeprom_dev_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .busy(busy), .wen(wen_q),
  .status_on(status_on), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/tw_eeprom_dev_bench.sv
`timescale 1ns/1ps
module tw_eeprom_dev_bench;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int PC = 200;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, dout_oe;

  int  nchk = 0, nfail = 0;
  bit  finished = 0;
  logic [DW-1:0] model [NW];
  bit  wen_m = 0;

  always #2.5 clk = ~clk;

  tw_eeprom_dev #(.DATA_W(DW), .ADDR_W(AW), .PROG_CYCLES(PC)) u_tw_eeprom_dev (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 16'h2F1B) ^ 16'h5AC3 ^ (a << 10));
  endfunction

  task automatic bit_out(input logic b);
    di = b; clk_n(4); sk = 1'b1; clk_n(4); sk = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1; clk_n(4);
  endtask

  task automatic cs_down();
    cs = 1'b0; di = 1'b0; clk_n(4);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a, input int nlead);
    repeat (nlead) bit_out(1'b0);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) bit_out(d[i]);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag, input bit rel);
    logic [DW-1:0] got;
    bit oe_ok;
    cs_up();
    send_hdr(2'b10, a, 0);
    clk_n(2);
    chk({tag, " R3 dummy bit"}, {30'd0, dout_oe, dout}, 32'd2);
    got = '0; oe_ok = 1;
    for (int i = 0; i < DW; i++) begin
      clk_n(2); sk = 1'b1; clk_n(4); sk = 1'b0; clk_n(2);
      got[DW-1-i] = dout;
      if (!dout_oe) oe_ok = 0;
    end
    chk(tag, 32'(got), 32'(model[a]));
    if (rel) begin
      chk("R3 enable held over 16 bits", 32'(oe_ok), 32'd1);
      clk_n(2); sk = 1'b1; clk_n(4); sk = 1'b0; clk_n(2);
      chk("R3 release after last bit", 32'(dout_oe), 32'd0);
    end
    cs_down();
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input int nlead);
    cs_up(); send_hdr(2'b01, a, nlead); send_data(d); cs_down(); clk_n(PC + 20);
    if (wen_m) model[a] = d;
  endtask

  task automatic erase_word(input logic [AW-1:0] a);
    cs_up(); send_hdr(2'b11, a, 0); cs_down(); clk_n(PC + 20);
    if (wen_m) model[a] = '1;
  endtask

  task automatic special(input logic [1:0] sel);
    cs_up(); send_hdr(2'b00, {sel, 4'b0000}, 0); cs_down();
    if (sel == 2'b11) wen_m = 1;
    if (sel == 2'b00) wen_m = 0;
  endtask

  task automatic erase_all();
    cs_up(); send_hdr(2'b00, {2'b10, 4'b0000}, 0); cs_down(); clk_n(PC + 20);
    if (wen_m) for (int i = 0; i < NW; i++) model[i] = '1;
  endtask

  task automatic write_all(input logic [DW-1:0] d);
    cs_up(); send_hdr(2'b00, {2'b01, 4'b0000}, 0); send_data(d); cs_down(); clk_n(PC + 20);
    if (wen_m) for (int i = 0; i < NW; i++) model[i] = d;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < NW; i++) model[i] = '1;
    clk_n(5);
    rst = 1'b0;
    clk_n(5);

    // R1: reset state
    chk("R1 oe after reset", 32'(dout_oe), 32'd0);
    rd_chk(0, "R1 word 0 erased", 1);
    rd_chk(63, "R1 word 63 erased", 0);

    // R5: locked writes and erases ignored
    write_word(3, 16'h1234, 0);
    rd_chk(3, "R5 locked write ignored", 0);
    erase_all();
    rd_chk(0, "R5 locked erase-all ignored", 0);

    // R4 unlock, R6 + R2 full address sweep with leading zeros
    special(2'b11);
    for (int a = 0; a < NW; a++) write_word(AW'(a), pat(a), (a % 2) * 2);
    for (int a = 0; a < NW; a++) rd_chk(AW'(a), "R6 sweep readback", 0);

    // R2: sk pulses with cs low have no effect
    cs = 1'b0; di = 1'b1;
    repeat (3) begin sk = 1'b1; clk_n(4); sk = 1'b0; clk_n(4); end
    rd_chk(5, "R2 sk with cs low ignored", 0);

    // R7: single erase leaves neighbours
    erase_word(10);
    rd_chk(9, "R7 neighbour below", 0);
    rd_chk(10, "R7 erased word", 0);
    rd_chk(11, "R7 neighbour above", 0);

    // R10 status, R9 cycle length, R12 release
    cs_up(); send_hdr(2'b01, 20, 0); send_data(16'hBEEF); model[20] = 16'hBEEF;
    cs_down(); cs_up();
    chk("R10 busy status", {30'd0, dout_oe, dout}, 32'd2);
    n = 0;
    while (dout == 1'b0 && n < PC + 50) begin clk_n(1); n++; end
    chk("R9 cycle length window", 32'(n >= PC - 14 && n <= PC - 4), 32'd1);
    chk("R10 ready status", {30'd0, dout_oe, dout}, 32'd3);
    clk_n(10);
    chk("R10 ready held", {30'd0, dout_oe, dout}, 32'd3);
    cs_down();
    chk("R12 oe low with cs low", 32'(dout_oe), 32'd0);
    rd_chk(20, "R6 write via status path", 0);

    // R11: cs raised after cycle end shows nothing
    erase_word(21);
    cs_up(); clk_n(4);
    chk("R11 no late status", 32'(dout_oe), 32'd0);
    cs_down();
    rd_chk(21, "R7 erase word 21", 0);

    // R9: sk ignored while busy
    cs_up(); send_hdr(2'b01, 22, 0); send_data(16'h0F0F); model[22] = 16'h0F0F;
    cs_down(); cs_up();
    chk("R10 first status busy", {30'd0, dout_oe, dout}, 32'd2);
    cs_down(); cs_up();
    chk("R11 status not repeated", 32'(dout_oe), 32'd0);
    send_hdr(2'b10, 22, 0);
    clk_n(2);
    chk("R9 read clocked while busy ignored", 32'(dout_oe), 32'd0);
    cs_down(); clk_n(PC + 20);
    rd_chk(22, "R9 word after busy window", 0);

    // R4 lock, R5 locked write, R3 read while locked
    special(2'b00);
    write_word(30, 16'hDEAD, 0);
    rd_chk(30, "R5 write after lock ignored", 0);

    // R8 whole-array write then erase
    special(2'b11);
    write_all(16'hC3A5);
    for (int a = 0; a < NW; a++) rd_chk(AW'(a), "R8 write-all", 0);
    erase_all();
    for (int a = 0; a < NW; a += 3) rd_chk(AW'(a), "R8 erase-all", 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule